// File: doc/BRIEF.md
# Paged program counter

This block holds the instruction address of a small 8-bit microcontroller core and decides, once per instruction cycle, where the next instruction comes from. The address is 13 bits wide, so it spans 8K words. Only the low byte is visible to the data path: it can be read and written. The upper five bits are never written directly. A separate 5-bit page latch supplies them whenever the address is loaded from the data path or from an instruction word.

The core presents one operation per instruction cycle on a 3-bit select, qualified by a cycle enable. There are seven named operations:

- **STEP** advances by one.
- **WRLOW** is a data-path write to the low byte.
- **ADDLOW** is a computed jump that adds an offset to the low byte.
- **GOTO** and **CALL** load an 11-bit target from the instruction word.
- **RET** reloads the full address from the return stack.
- **IRQ** branches to a fixed vector.

CALL and IRQ offer the incremented current address to the external return stack in the same cycle. The stack itself, instruction decoding and the ALU are outside this block.

The block has no state machine of its own. Its two pieces of state are the address register and the page latch. The operation select acts as the transition label: the next address is chosen from it on every enabled cycle, and when the enable is low the address stays where it is.

Top module: `pc_pager`

## Requirements
- R1: While `rst_n` is low and after it is released, `pc_addr` is 0 and the page latch holds 0.
- R2: With `cyc_en`=1 and `op`=0 (STEP), `pc_addr` advances by one on the next clock and wraps from 13'h1FFF to 13'h0000.
- R3: With `cyc_en`=0, `pc_addr` keeps its value whatever `op` carries, and `push_en` stays 0.
- R4: With `op`=1 (WRLOW), the next address is {latch[4:0], `dat_in`}.
- R5: With `op`=2 (ADDLOW), the next low byte is (current low byte + `dat_in`) mod 256 with the carry discarded, and the upper five bits come from latch[4:0].
- R6: With `op`=3 (GOTO), the next address is {latch[4:3], `ins_tgt`[10:0]}.
- R7: With `op`=4 (CALL), the address loads as for GOTO, and in the same cycle `push_en`=1 and `push_addr` = (current address + 1) mod 8192.
- R8: With `op`=5 (RET), the next address is `stk_pop`, and the page latch is left unchanged.
- R9: With `op`=6 (IRQ), the next address is the vector parameter (default 13'h0004), and the push port behaves as in R7.
- R10: `lat_we`=1 stores `lat_wd` into the page latch at the clock edge, independent of `cyc_en`. A load in the same cycle as a latch write uses the latch's previous contents.
- R11: `pcl_rd` always equals `pc_addr`[7:0].
- R12: The reserved value `op`=7 behaves as STEP.
- R13: GOTO and CALL ignore latch bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable |
| op | input | 3 | Operation select: 0 STEP, 1 WRLOW, 2 ADDLOW, 3 GOTO, 4 CALL, 5 RET, 6 IRQ, 7 reserved |
| dat_in | input | 8 | Low-byte write value or computed-jump offset |
| ins_tgt | input | 11 | Branch target field from the instruction word |
| stk_pop | input | 13 | Address returned by the stack |
| lat_we | input | 1 | Page latch write enable |
| lat_wd | input | 5 | Page latch write data |
| pc_addr | output | 13 | Program memory address |
| pcl_rd | output | 8 | Readable low byte of the address |
| push_en | output | 1 | Push request to the return stack |
| push_addr | output | 13 | Return address to push |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 8-bit low byte, an 11-bit branch field and the vector at 4. Because the space is only 8K words, the bench can step through every address, including the wrap from the top back to zero.

It also sweeps the full 5-bit latch range through low-byte writes, GOTO and CALL. Each of the 256 offsets is applied to the computed jump, so every carry out of the low byte is seen.

Every operation code is also issued with the enable low. Each expected address is computed arithmetically from a model of the address and the latch.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_WRLOW  = 3'd1,
        OP_ADDLOW = 3'd2,
        OP_GOTO   = 3'd3,
        OP_CALL   = 3'd4,
        OP_RET    = 3'd5,
        OP_IRQ    = 3'd6,
        OP_RSVD   = 3'd7
    } pc_op_e;

endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
    parameter int HI_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [HI_W-1:0] wd,
    output logic [HI_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wd;
        end
    end

    // R10: a write lands at the edge; without a write the latch holds
    a_r10_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wd));
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int            PC_W  = 13,
    parameter int            LOW_W = 8,
    parameter int            BR_W  = 11,
    parameter logic [PC_W-1:0] VEC = 13'h0004
) (
    input  logic [PC_W-1:0]       cur,
    input  logic                  en,
    input  logic [2:0]            op,
    input  logic [LOW_W-1:0]      dat,
    input  logic [BR_W-1:0]       tgt,
    input  logic [PC_W-1:0]       pop,
    input  logic [PC_W-LOW_W-1:0] lat,
    output logic [PC_W-1:0]       nxt,
    output logic                  push_en,
    output logic [PC_W-1:0]       push_addr
);

    localparam int HI_W   = PC_W - LOW_W;
    localparam int PG_LSB = BR_W - LOW_W;

    pc_op_e          op_e;
    logic [PC_W-1:0] inc;
    logic [LOW_W-1:0] low_sum;

    assign op_e    = pc_op_e'(op);
    assign inc     = cur + PC_W'(1);
    assign low_sum = cur[LOW_W-1:0] + dat;

    // next-address selection
    always_comb begin
        nxt = cur;
        if (en) begin
            unique case (op_e)
                OP_STEP, OP_RSVD: nxt = inc;
                OP_WRLOW:         nxt = {lat, dat};
                OP_ADDLOW:        nxt = {lat, low_sum};
                OP_GOTO, OP_CALL: nxt = {lat[HI_W-1:PG_LSB], tgt};
                OP_RET:           nxt = pop;
                OP_IRQ:           nxt = VEC;
            endcase
        end
    end

    // push request toward the return stack
    always_comb begin
        push_en   = 1'b0;
        push_addr = inc;
        if (en) begin
            unique case (op_e)
                OP_CALL, OP_IRQ: push_en = 1'b1;
                default:         push_en = 1'b0;
            endcase
        end
    end

    // R3: a disabled cycle never pushes and leaves the address alone
    always_comb begin
        if (!en) begin
            a_r3_idle_comb: assert (!push_en && nxt == cur);
        end
    end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
    parameter int PC_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pc_pager.sv
module pc_pager
    import pcu_pkg::*;
#(
    parameter int              PC_W  = 13,
    parameter int              LOW_W = 8,
    parameter int              BR_W  = 11,
    parameter logic [PC_W-1:0] VEC   = 13'h0004
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_en,
    input  logic [2:0]            op,
    input  logic [LOW_W-1:0]      dat_in,
    input  logic [BR_W-1:0]       ins_tgt,
    input  logic [PC_W-1:0]       stk_pop,
    input  logic                  lat_we,
    input  logic [PC_W-LOW_W-1:0] lat_wd,
    output logic [PC_W-1:0]       pc_addr,
    output logic [LOW_W-1:0]      pcl_rd,
    output logic                  push_en,
    output logic [PC_W-1:0]       push_addr
);

    localparam int HI_W   = PC_W - LOW_W;
    localparam int PG_LSB = BR_W - LOW_W;

    logic [HI_W-1:0] lat_q;
    logic [PC_W-1:0] nxt_pc;

    pcu_page_latch #(.HI_W(HI_W)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lat_we),
        .wd    (lat_wd),
        .q     (lat_q)
    );

    pcu_next_addr #(
        .PC_W  (PC_W),
        .LOW_W (LOW_W),
        .BR_W  (BR_W),
        .VEC   (VEC)
    ) i_next (
        .cur       (pc_addr),
        .en        (cyc_en),
        .op        (op),
        .dat       (dat_in),
        .tgt       (ins_tgt),
        .pop       (stk_pop),
        .lat       (lat_q),
        .nxt       (nxt_pc),
        .push_en   (push_en),
        .push_addr (push_addr)
    );

    pcu_pc_reg #(.PC_W(PC_W)) i_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_pc),
        .q     (pc_addr)
    );

    assign pcl_rd = pc_addr[LOW_W-1:0];

    // R2 / R12: sequential advance with wrap
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && (op == OP_STEP || op == OP_RSVD))
        |=> pc_addr == PC_W'($past(pc_addr) + 1));
    // R3: disabled cycles hold the address
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pc_addr));
    // R4: low-byte write takes the full upper field from the latch
    a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == OP_WRLOW)
        |=> pc_addr == {$past(lat_q), $past(dat_in)});
    // R5: computed jump drops the carry out of the low byte
    a_r5_add_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == OP_ADDLOW)
        |=> pc_addr == {$past(lat_q),
                        LOW_W'($past(pc_addr[LOW_W-1:0]) + $past(dat_in))});
    // R6 / R13: branch uses only the page bits of the latch
    a_r6_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && (op == OP_GOTO || op == OP_CALL))
        |=> pc_addr == {$past(lat_q[HI_W-1:PG_LSB]), $past(ins_tgt)});
    // R7: a call pushes the incremented address in the same cycle
    a_r7_push: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == OP_CALL)
        |-> push_en && push_addr == PC_W'(pc_addr + 1));
    // R8: return reloads all bits and keeps the latch
    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == OP_RET && !lat_we)
        |=> pc_addr == $past(stk_pop) && $stable(lat_q));
    // R9: interrupt goes to the vector
    a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op == OP_IRQ) |=> pc_addr == VEC);

endmodule

// File: tb/test_pc_pager.sv
module test_pc_pager;

    localparam logic [12:0] VEC = 13'h0004;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc_en;
    logic [2:0]  op;
    logic [7:0]  dat_in;
    logic [10:0] ins_tgt;
    logic [12:0] stk_pop;
    logic        lat_we;
    logic [4:0]  lat_wd;
    logic [12:0] pc_addr;
    logic [7:0]  pcl_rd;
    logic        push_en;
    logic [12:0] push_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [12:0] e_pc;
    logic [4:0]  e_lat;

    always #4 clk = ~clk;

    pc_pager i_pc_pager (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .op        (op),
        .dat_in    (dat_in),
        .ins_tgt   (ins_tgt),
        .stk_pop   (stk_pop),
        .lat_we    (lat_we),
        .lat_wd    (lat_wd),
        .pc_addr   (pc_addr),
        .pcl_rd    (pcl_rd),
        .push_en   (push_en),
        .push_addr (push_addr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog (all R) actual=%0d cycles expected=fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // called just after a falling edge; ends just after the next one
    task automatic run(input logic en, input logic [2:0] o, input logic [7:0] d,
                       input logic [10:0] t, input logic [12:0] p,
                       input logic lw, input logic [4:0] lv, input string req);
        logic [12:0] nx;
        logic        pe;
        cyc_en = en; op = o; dat_in = d; ins_tgt = t; stk_pop = p;
        lat_we = lw; lat_wd = lv;
        pe = en && (o == 3'd4 || o == 3'd6);
        nx = e_pc;
        if (en) begin
            case (o)
                3'd0, 3'd7: nx = 13'(e_pc + 1);
                3'd1:       nx = {e_lat, d};
                3'd2:       nx = {e_lat, 8'(e_pc[7:0] + d)};
                3'd3, 3'd4: nx = {e_lat[4:3], t};
                3'd5:       nx = p;
                default:    nx = VEC;
            endcase
        end
        #1;
        chk_eq(req, "push_en", 32'(push_en), 32'(pe));
        if (pe) chk_eq({req, " R7"}, "push_addr", 32'(push_addr), 32'(13'(e_pc + 1)));
        @(negedge clk);
        e_pc = nx;
        if (lw) e_lat = lv;
        chk_eq(req, "pc_addr", 32'(pc_addr), 32'(e_pc));
        chk_eq({req, " R11"}, "pcl_rd", 32'(pcl_rd), 32'(e_pc[7:0]));
    endtask

    initial begin
        rst_n = 1'b0; cyc_en = 1'b0; op = 3'd0; dat_in = '0; ins_tgt = '0;
        stk_pop = '0; lat_we = 1'b0; lat_wd = '0;
        e_pc = '0; e_lat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_eq("R1", "pc_addr in reset", 32'(pc_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "pc_addr after reset", 32'(pc_addr), 32'h0);
        // R1: latch is 0, seen through a low-byte write
        run(1, 3'd1, 8'h5A, '0, '0, 0, '0, "R1");

        // R2: walk the whole space, crossing 1FFF -> 0
        for (int i = 0; i < 8192; i++) run(1, 3'd0, '0, '0, '0, 0, '0, "R2");

        // R4 R6 R7 R10 R13: every latch value
        for (int l = 0; l < 32; l++) begin
            run(1, 3'd0, '0, '0, '0, 1, 5'(l), "R10");
            run(1, 3'd1, 8'(l * 37 + 5), '0, '0, 0, '0, "R4");
            run(1, 3'd3, '0, 11'(l * 97 + 13), '0, 0, '0, "R6 R13");
            run(1, 3'd4, '0, 11'(l * 211 + 1), '0, 0, '0, "R7");
        end

        // R10: load in the same cycle as a latch write uses the old value
        run(1, 3'd0, '0, '0, '0, 1, 5'h03, "R10");
        run(1, 3'd1, 8'h11, '0, '0, 1, 5'h1C, "R10");
        run(1, 3'd1, 8'h22, '0, '0, 0, '0, "R10");

        // R5: all offsets, carries dropped
        run(1, 3'd0, '0, '0, '0, 1, 5'h0A, "R5");
        run(1, 3'd1, 8'hF0, '0, '0, 0, '0, "R5");
        for (int k = 0; k < 256; k++) run(1, 3'd2, 8'(k), '0, '0, 0, '0, "R5");
        run(1, 3'd0, '0, '0, '0, 1, 5'h15, "R5");
        run(1, 3'd2, 8'hE0, '0, '0, 0, '0, "R5");

        // R8: returns, then the latch is still intact
        for (int j = 0; j < 16; j++) begin
            run(1, 3'd5, '0, '0, 13'(j * 523 + 7), 0, '0, "R8");
            run(1, 3'd3, '0, 11'h155, '0, 0, '0, "R8");
        end

        // R9: interrupt vector with push, then return
        run(1, 3'd1, 8'h77, '0, '0, 0, '0, "R9");
        run(1, 3'd6, '0, '0, '0, 0, '0, "R9");
        run(1, 3'd5, '0, '0, 13'h1578, 0, '0, "R9");

        // R3: every code with the enable low
        for (int o = 0; o < 8; o++) run(0, 3'(o), 8'hA5, 11'h6C3, 13'h0F0F, 0, '0, "R3");

        // R12: reserved code advances
        run(1, 3'd7, 8'hFF, 11'h7FF, 13'h1FFF, 0, '0, "R12");
        run(1, 3'd7, '0, '0, '0, 0, '0, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule